// File: doc/BRIEF.md
# Register Rename and Allocate Unit

This block sits at the issue point of an out-of-order execution core. Each issuing instruction names up to two source registers and one destination register from the architected file. The block translates both sources through a rename map. It gives the destination a physical register that nothing else holds, and it records that new mapping. Because each physical register receives exactly one result after it is handed out, later writers never disturb values that earlier readers still need.

The block keeps a valid flag and a value for every physical register. It fills them by snooping a result broadcast bus that carries a tag and a value. An issued instruction therefore gets one of two answers for each operand. If the result is already known, it gets the value. If not, it gets the tag it must wait for. The commit stage hands back the physical register that a retired destination used to map to, and that register returns to the pool. Recovery from mispredicted branches is not part of this block, and it handles at most one instruction per cycle.

Top module: `rn_rename_top`

## Requirements
- R1: After reset, architected register i maps to physical register i for every architected register. Those physical registers hold value 0 with valid set. All remaining physical registers are free.
- R2: An accepted instruction with a destination other than register 0 receives the lowest-numbered free physical register on `dst_tag`. The map entry for its destination then points to that register, and `dst_prev_tag` reports the physical register the destination mapped to before.
- R3: Source operands are translated through the map as it was before the same instruction's destination is renamed. A source equal to the destination therefore gets the old tag.
- R4: A newly allocated physical register has valid cleared, even if it held a value before. A source that maps to it returns its tag with valid 0 until the bus writes it.
- R5: A bus write with `bus_valid` high stores the value and sets valid for that tag. Later lookups of that tag return the value with valid 1.
- R6: When a bus write and a source lookup name the same physical register in one cycle, the operand returns the bus value with valid 1.
- R7: `iss_ready` is low only when the free pool is empty and the instruction needs a destination. An instruction without a destination is accepted even when the pool is empty. The pool state is registered, so a release in the same cycle does not raise `iss_ready`.
- R8: A release with `rel_valid` high returns `rel_tag` to the free pool from the next cycle on. A later allocation takes it if it is then the lowest free register.
- R9: Architected register 0 always reads as physical register 0, valid, value 0. A destination of 0 allocates nothing and reports `dst_tag` and `dst_prev_tag` as 0. Bus writes and releases of tag 0 are ignored.
- R10: With `iss_valid` low, neither the map nor the free pool changes, whatever the other issue inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for issue |
| iss_ready | output | 1 | The presented instruction can be accepted this cycle |
| iss_src_a | input | 5 | Architected number of the first source |
| iss_src_b | input | 5 | Architected number of the second source |
| iss_has_dst | input | 1 | The instruction writes a register |
| iss_dst | input | 5 | Architected number of the destination |
| opa_tag | output | 6 | Physical register of the first source |
| opa_valid | output | 1 | First source value is known |
| opa_value | output | 32 | First source value, meaningful when valid |
| opb_tag | output | 6 | Physical register of the second source |
| opb_valid | output | 1 | Second source value is known |
| opb_value | output | 32 | Second source value, meaningful when valid |
| dst_tag | output | 6 | Newly allocated physical register, 0 when none |
| dst_prev_tag | output | 6 | Physical register the destination mapped to before, 0 when none |
| bus_valid | input | 1 | A result is broadcast this cycle |
| bus_tag | input | 6 | Physical register the result belongs to |
| bus_value | input | 32 | Result value |
| rel_valid | input | 1 | Commit returns a physical register |
| rel_tag | input | 6 | Physical register being returned |

## Verification
The checker assumes that the environment is well behaved. Commit releases only registers that are currently handed out and never tag 0. The bus carries results only for registers that have been allocated, and a register is never released in the cycle after it was allocated. The bench holds to this because it keeps its own model of the free pool and the map. It releases only tags that the model shows as in use, and it broadcasts only to tags that the model has allocated. Its checks are computed from that model's lowest-free choice, its map and its valid flags, and the cases it covers are forwarding, reuse of a released tag, and an empty pool.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int unsigned RN_ARCH_REGS = 32;
  localparam int unsigned RN_PHYS_REGS = 64;
  localparam int unsigned RN_DATA_W    = 32;
endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
  parameter int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  parameter int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  logic          rel_en,
  input  logic [PW-1:0] rel_tag,
  output logic [PW-1:0] alloc_tag,
  output logic          empty,
  output logic          rel_was_free
);
  logic [PHYS_REGS-1:0] free_q;

  // lowest set bit, scanned from the top so the smallest index wins
  function automatic logic [PW-1:0] lowest_set(input logic [PHYS_REGS-1:0] v);
    logic [PW-1:0] r;
    r = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (v[i]) r = PW'(i);
    end
    return r;
  endfunction

  assign alloc_tag    = lowest_set(free_q);
  assign empty        = (free_q == '0);
  assign rel_was_free = free_q[rel_tag];

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_slot
    localparam logic [PW-1:0] IDX = PW'(g);
    localparam logic          RST_FREE = (g >= ARCH_REGS);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        free_q[g] <= RST_FREE;
      end else if (alloc_en && alloc_tag == IDX) begin
        free_q[g] <= 1'b0;
      end else if (rel_en && rel_tag == IDX && g != 0) begin
        free_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  parameter int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_a,
  input  logic [AW-1:0] rd_b,
  output logic [PW-1:0] tag_a,
  output logic [PW-1:0] tag_b,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_arch,
  input  logic [PW-1:0] wr_tag,
  output logic [PW-1:0] wr_prev
);
  logic [PW-1:0] map_q [ARCH_REGS];

  assign tag_a   = map_q[rd_a];
  assign tag_b   = map_q[rd_b];
  assign wr_prev = map_q[wr_arch];

  for (genvar g = 0; g < ARCH_REGS; g++) begin : g_ent
    localparam logic [AW-1:0] IDX = AW'(g);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        map_q[g] <= PW'(g);
      end else if (wr_en && wr_arch == IDX && g != 0) begin
        map_q[g] <= wr_tag;
      end
    end
  end
endmodule

// File: rtl/rn_phys_file.sv
module rn_phys_file #(
  parameter int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  parameter int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  parameter int unsigned DATA_W    = rn_pkg::RN_DATA_W,
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_en,
  input  logic [PW-1:0]     clr_tag,
  input  logic [PW-1:0]     rd_a,
  input  logic [PW-1:0]     rd_b,
  output logic              vld_a,
  output logic [DATA_W-1:0] val_a,
  output logic              vld_b,
  output logic [DATA_W-1:0] val_b
);
  logic              vld_q [PHYS_REGS];
  logic [DATA_W-1:0] val_q [PHYS_REGS];
  logic              wr_live;

  assign wr_live = wr_en && (wr_tag != '0);

  // forwarding: a bus write to the tag being read wins over the stored copy
  function automatic logic fwd_hit(input logic live, input logic [PW-1:0] wt,
                                   input logic [PW-1:0] rt);
    return live && (wt == rt);
  endfunction

  always_comb begin
    if (fwd_hit(wr_live, wr_tag, rd_a)) begin
      vld_a = 1'b1;
      val_a = wr_data;
    end else begin
      vld_a = vld_q[rd_a];
      val_a = val_q[rd_a];
    end
    if (fwd_hit(wr_live, wr_tag, rd_b)) begin
      vld_b = 1'b1;
      val_b = wr_data;
    end else begin
      vld_b = vld_q[rd_b];
      val_b = val_q[rd_b];
    end
  end

  for (genvar g = 0; g < PHYS_REGS; g++) begin : g_reg
    localparam logic [PW-1:0] IDX = PW'(g);
    localparam logic          RST_VLD = (g < ARCH_REGS);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= RST_VLD;
        val_q[g] <= '0;
      end else if (clr_en && clr_tag == IDX) begin
        vld_q[g] <= 1'b0;
      end else if (wr_live && wr_tag == IDX) begin
        vld_q[g] <= 1'b1;
        val_q[g] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/rn_rename_top.sv
module rn_rename_top #(
  parameter int unsigned ARCH_REGS = rn_pkg::RN_ARCH_REGS,
  parameter int unsigned PHYS_REGS = rn_pkg::RN_PHYS_REGS,
  parameter int unsigned DATA_W    = rn_pkg::RN_DATA_W,
  localparam int unsigned AW = $clog2(ARCH_REGS),
  localparam int unsigned PW = $clog2(PHYS_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [AW-1:0]     iss_src_a,
  input  logic [AW-1:0]     iss_src_b,
  input  logic              iss_has_dst,
  input  logic [AW-1:0]     iss_dst,
  output logic [PW-1:0]     opa_tag,
  output logic              opa_valid,
  output logic [DATA_W-1:0] opa_value,
  output logic [PW-1:0]     opb_tag,
  output logic              opb_valid,
  output logic [DATA_W-1:0] opb_value,
  output logic [PW-1:0]     dst_tag,
  output logic [PW-1:0]     dst_prev_tag,
  input  logic              bus_valid,
  input  logic [PW-1:0]     bus_tag,
  input  logic [DATA_W-1:0] bus_value,
  input  logic              rel_valid,
  input  logic [PW-1:0]     rel_tag
);
  // named internal events for the checker
  logic          needs_dst;
  logic          iss_fire;
  logic          alloc_fire;
  logic [PW-1:0] alloc_tag;
  logic          pool_empty;
  logic          rel_was_free;
  logic [PW-1:0] prev_tag;

  assign needs_dst  = iss_has_dst && (iss_dst != '0);
  assign iss_ready  = !needs_dst || !pool_empty;
  assign iss_fire   = iss_valid && iss_ready;
  assign alloc_fire = iss_fire && needs_dst;

  rn_free_list #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS)) free_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_en     (alloc_fire),
    .rel_en       (rel_valid),
    .rel_tag      (rel_tag),
    .alloc_tag    (alloc_tag),
    .empty        (pool_empty),
    .rel_was_free (rel_was_free)
  );

  rn_map_table #(.ARCH_REGS(ARCH_REGS), .PHYS_REGS(PHYS_REGS)) map_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_a    (iss_src_a),
    .rd_b    (iss_src_b),
    .tag_a   (opa_tag),
    .tag_b   (opb_tag),
    .wr_en   (alloc_fire),
    .wr_arch (iss_dst),
    .wr_tag  (alloc_tag),
    .wr_prev (prev_tag)
  );

  rn_phys_file #(.PHYS_REGS(PHYS_REGS), .ARCH_REGS(ARCH_REGS), .DATA_W(DATA_W)) prf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_valid),
    .wr_tag  (bus_tag),
    .wr_data (bus_value),
    .clr_en  (alloc_fire),
    .clr_tag (alloc_tag),
    .rd_a    (opa_tag),
    .rd_b    (opb_tag),
    .vld_a   (opa_valid),
    .val_a   (opa_value),
    .vld_b   (opb_valid),
    .val_b   (opb_value)
  );

  assign dst_tag      = needs_dst ? alloc_tag : '0;
  assign dst_prev_tag = needs_dst ? prev_tag  : '0;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6,
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_ready,
  input logic          needs_dst,
  input logic          alloc_fire,
  input logic [PW-1:0] alloc_tag,
  input logic [AW-1:0] iss_src_a,
  input logic [PW-1:0] opa_tag,
  input logic          opa_valid,
  input logic [DW-1:0] opa_value,
  input logic          bus_valid,
  input logic [PW-1:0] bus_tag,
  input logic [DW-1:0] bus_value,
  input logic          rel_valid,
  input logic [PW-1:0] rel_tag,
  input logic          rel_was_free
);
  assert_fresh_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (!alloc_fire || alloc_tag != $past(alloc_tag)));

  assert_bus_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_tag == opa_tag && bus_tag != '0) |-> (opa_valid && opa_value == bus_value));

  assert_stall_needs_dst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> needs_dst);

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src_a == '0) |-> (opa_tag == '0 && opa_valid && opa_value == '0));

  assert_release_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rel_valid |-> (!rel_was_free && rel_tag != '0));
endmodule

bind rn_rename_top rn_rename_chk #(.AW(AW), .PW(PW), .DW(DATA_W)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .iss_ready    (iss_ready),
  .needs_dst    (needs_dst),
  .alloc_fire   (alloc_fire),
  .alloc_tag    (alloc_tag),
  .iss_src_a    (iss_src_a),
  .opa_tag      (opa_tag),
  .opa_valid    (opa_valid),
  .opa_value    (opa_value),
  .bus_valid    (bus_valid),
  .bus_tag      (bus_tag),
  .bus_value    (bus_value),
  .rel_valid    (rel_valid),
  .rel_tag      (rel_tag),
  .rel_was_free (rel_was_free)
);

// File: tb/rn_rename_top_tb.sv
`timescale 1ns/1ps
module rn_rename_top_tb_top;
  localparam int NA = 32;
  localparam int NP = 64;

  typedef struct {
    logic        rdy;
    logic [5:0]  ta;
    logic        va;
    logic [31:0] xa;
    logic [5:0]  tb;
    logic        vb;
    logic [31:0] xb;
    logic [5:0]  td;
    logic [5:0]  tp;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic iss_valid = 1'b0, iss_has_dst = 1'b0;
  logic [4:0] iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic bus_valid = 1'b0, rel_valid = 1'b0;
  logic [5:0] bus_tag = '0, rel_tag = '0;
  logic [31:0] bus_value = '0;
  logic iss_ready, opa_valid, opb_valid;
  logic [5:0] opa_tag, opb_tag, dst_tag, dst_prev_tag;
  logic [31:0] opa_value, opb_value;

  always #2 clk = ~clk;

  rn_rename_top dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_has_dst(iss_has_dst),
    .iss_dst(iss_dst), .opa_tag(opa_tag), .opa_valid(opa_valid), .opa_value(opa_value),
    .opb_tag(opb_tag), .opb_valid(opb_valid), .opb_value(opb_value),
    .dst_tag(dst_tag), .dst_prev_tag(dst_prev_tag), .bus_valid(bus_valid),
    .bus_tag(bus_tag), .bus_value(bus_value), .rel_valid(rel_valid), .rel_tag(rel_tag)
  );

  int checks = 0;
  int errors = 0;
  exp_t  exp_q[$];
  string req_q[$];

  // reference model state
  int          map_m [NA];
  bit          free_m[NP];
  bit          vld_m [NP];
  logic [31:0] dat_m [NP];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int lowest_free();
    for (int i = 0; i < NP; i++) if (free_m[i]) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NA; i++) map_m[i] = i;
    for (int i = 0; i < NP; i++) begin
      free_m[i] = (i >= NA);
      vld_m[i]  = (i < NA);
      dat_m[i]  = '0;
    end
  endtask

  task automatic lookup(input int s, input bit bv, input int bt, input logic [31:0] bd,
                        output logic [5:0] t, output logic v, output logic [31:0] x);
    t = 6'(map_m[s]);
    if (bv && bt != 0 && bt == map_m[s]) begin
      v = 1'b1; x = bd;
    end else begin
      v = vld_m[map_m[s]]; x = dat_m[map_m[s]];
    end
  endtask

  // driver: one cycle of stimulus, expected result pushed to the scoreboard
  task automatic step(input bit v, input int sa, input int sb, input bit hd, input int d,
                      input bit bv, input int bt, input logic [31:0] bd,
                      input bit rv, input int rt, input string req);
    exp_t e;
    bit need;
    int lf;
    @(posedge clk); #1;
    iss_valid = v; iss_src_a = 5'(sa); iss_src_b = 5'(sb);
    iss_has_dst = hd; iss_dst = 5'(d);
    bus_valid = bv; bus_tag = 6'(bt); bus_value = bd;
    rel_valid = rv; rel_tag = 6'(rt);
    need = hd && (d != 0);
    lf = lowest_free();
    e.rdy = !need || (lf >= 0);
    lookup(sa, bv, bt, bd, e.ta, e.va, e.xa);
    lookup(sb, bv, bt, bd, e.tb, e.vb, e.xb);
    e.td = need ? 6'(lf) : 6'd0;
    e.tp = need ? 6'(map_m[d]) : 6'd0;
    if (v) begin
      exp_q.push_back(e);
      req_q.push_back(req);
    end
    if (bv && bt != 0) begin vld_m[bt] = 1'b1; dat_m[bt] = bd; end
    if (rv && rt != 0) free_m[rt] = 1'b1;
    if (v && e.rdy && need) begin
      free_m[lf] = 1'b0; vld_m[lf] = 1'b0; map_m[d] = lf;
    end
  endtask

  // monitor: compares the design's results with the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && iss_valid && exp_q.size() > 0) begin
        exp_t e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        chk(iss_ready == e.rdy, r, "ready", 32'(iss_ready), 32'(e.rdy));
        if (e.rdy) begin
          chk(opa_tag == e.ta && opa_valid == e.va, r, "opa tag/valid",
              {opa_valid, 25'd0, opa_tag}, {e.va, 25'd0, e.ta});
          if (e.va) chk(opa_value == e.xa, r, "opa value", opa_value, e.xa);
          chk(opb_tag == e.tb && opb_valid == e.vb, r, "opb tag/valid",
              {opb_valid, 25'd0, opb_tag}, {e.vb, 25'd0, e.tb});
          if (e.vb) chk(opb_value == e.xb, r, "opb value", opb_value, e.xb);
          chk(dst_tag == e.td, r, "dst tag", 32'(dst_tag), 32'(e.td));
          chk(dst_prev_tag == e.tp, r, "prev tag", 32'(dst_prev_tag), 32'(e.tp));
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    chk(1'b0, "watchdog", "timeout", 32'(cyc), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(iss_ready == 1'b1, "R1", "ready after reset", 32'(iss_ready), 32'd1);
    // R1 and R2: reset mapping, first allocation takes the lowest free tag
    step(1, 5, 6, 1, 7, 0, 0, 0, 0, 0, "R1 R2");
    // R3 / R4: source equal to destination sees the old tag; new tag not valid
    step(1, 7, 7, 1, 7, 0, 0, 0, 0, 0, "R3 R4");
    // R6: same-cycle forwarding from the bus
    step(1, 7, 1, 1, 8, 1, 33, 32'hAA, 0, 0, "R6");
    // R5: stored value read back later
    step(1, 7, 8, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R9: register zero, bus write to tag 0 ignored
    step(1, 0, 0, 1, 0, 1, 0, 32'h123, 0, 0, "R9");
    step(1, 0, 7, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R10: idle cycles carrying a destination change nothing
    step(0, 9, 0, 1, 9, 0, 0, 0, 0, 0, "R10");
    step(0, 3, 0, 1, 3, 0, 0, 0, 0, 0, "R10");
    step(1, 9, 3, 1, 9, 0, 0, 0, 0, 0, "R10");
    // R2: drain the pool with a spread of destinations and bus traffic
    for (int k = 0; k < 28; k++) begin
      step(1, 1 + (k % 7), 10 + (k % 20), 1, 10 + (k % 20),
           (k % 5) == 0, 35, 32'(k + 1000), 0, 0, "R2");
    end
    // R7: empty pool stalls a destination, not a destination-free instruction
    step(1, 3, 4, 1, 11, 0, 0, 0, 0, 0, "R7");
    step(1, 3, 4, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R7: release in the same cycle does not raise ready
    step(1, 3, 4, 1, 12, 0, 0, 0, 1, 32, "R7");
    // R8: released tag is reused
    step(1, 12, 4, 1, 12, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 40, "R8");
    step(0, 0, 0, 0, 0, 1, 36, 32'h5, 0, 0, "R8");
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 36, "R8");
    step(1, 12, 0, 1, 13, 0, 0, 0, 0, 0, "R8");
    // R4: reused tag that held a value comes back not valid
    step(1, 13, 12, 1, 14, 0, 0, 0, 0, 0, "R4");
    // R5: write the reallocated tag, then read it
    step(0, 0, 0, 0, 0, 1, 36, 32'hBEEF, 0, 0, "R5");
    step(1, 13, 14, 0, 0, 0, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    @(posedge clk); #1;
    @(negedge clk);
    chk(exp_q.size() == 0, "R2", "scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule